// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the shared control and status register file of a multi-channel DMA controller. Software reaches it over a simple 32-bit register bus with per-byte write strobes and a combinational read port. It holds four per-channel bitmaps: request enable, error-interrupt enable, interrupt pending and error pending. Each bitmap is seen by software as a pair of 32-bit words. The high word covers channels 63..32 and the low word covers channels 31..0. With 32 or fewer channels only the low words hold state.

Single channels are changed without read-modify-write. Two command words carry eight byte-wide commands. Each command byte names one channel, and the command sets or clears that channel's bit, or fires a one-cycle start or clear-done strobe towards that channel's engine. The channel engines report completion through a per-channel done bitmap. They report failures through a single error-report port that carries a channel number and a cause code. The first error report is frozen in an error status word until software releases it. A single interrupt line summarizes the pending state.

Top module: `dmac_regbank`

## Requirements
- R1: After reset every readable register reads 0, `irq` is low, and all per-channel outputs are 0.
- R2: The control word at offset 0x00 stores bit 31 (dynamic clock enable, lane 3) and bits 3 and 2 (round-robin group and channel arbitration, lane 0). These drive `ctrl_dyn_clk`, `ctrl_rr_group` and `ctrl_rr_chan`. All other bits read 0.
- R3: Request enable can be written directly at 0x08 (high) and 0x0C (low), honouring byte strobes. In the command word at 0x18, lane 0 sets and lane 1 clears the request enable of the channel named by that byte. The bitmap is visible on `ch_req_en`.
- R4: Error-interrupt enable works like R3, with direct words at 0x10 (high) and 0x14 (low). In the command word at 0x18, lane 2 sets the bit and lane 3 clears it.
- R5: A bit of `ch_done_evt` sets that channel's interrupt-pending bit, read at 0x20 (high) and 0x24 (low). Lane 0 of the command word at 0x1C clears one channel. Writing ones to 0x20 or 0x24 clears the matching bits in the enabled bytes. If a set and a clear hit the same channel in the same cycle, the set wins.
- R6: An error report with `err_rpt_valid` sets the error-pending bit of `err_rpt_chan`, read at 0x28 (high) and 0x2C (low). It is cleared by lane 1 of the command word at 0x1C, or by writing ones to 0x28 or 0x2C. A set wins over a same-cycle clear.
- R7: The error status word at 0x04 has this layout: bit 31 valid, bit 15 group priority error, bit 14 channel priority error, bits 13:8 channel, bits 7:0 the cause bits. `err_rpt_cause[9:8]` feeds bits 15:14 and `err_rpt_cause[7:0]` feeds bits 7:0. The word captures a report only while valid is clear, or in the same cycle that software clears it. Software clears the word by writing 1 to bit 31 with lane 3 enabled.
- R8: `irq` is high when any interrupt-pending bit is set, or when any channel has both its error-pending bit and its error-interrupt enable set.
- R9: In the command word at 0x1C, lane 2 (start) and lane 3 (clear done) produce a one-cycle strobe on `ch_start` and `ch_done_clr` respectively. The strobe appears in the cycle after the write and carries only the named channel's bit.
- R10: A command byte whose value is at or above the channel count changes no bit and produces no strobe.
- R11: Channel n maps to bit n of the low word for n < 32, and to bit n-32 of the high word for n >= 32. Accesses whose address is not one of the listed word offsets are ignored and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release already synchronized |
| reg_wr_en | input | 1 | Register write request |
| reg_addr | input | 8 | Byte address of the accessed word (read and write) |
| reg_wstrb | input | 4 | Byte enables of the write, lane 0 = bits 7:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at `reg_addr` |
| ch_done_evt | input | NUM_CH | Per-channel completion events |
| err_rpt_valid | input | 1 | Error report strobe |
| err_rpt_chan | input | 6 | Channel of the error report |
| err_rpt_cause | input | 10 | Cause code of the error report |
| ch_req_en | output | NUM_CH | Request enable bitmap |
| ch_start | output | NUM_CH | Software start strobes |
| ch_done_clr | output | NUM_CH | Clear-done strobes |
| ctrl_dyn_clk | output | 1 | Dynamic clock enable |
| ctrl_rr_group | output | 1 | Round-robin group arbitration |
| ctrl_rr_chan | output | 1 | Round-robin channel arbitration |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situations to reach from the ports are the races. One is a channel event and a software clear landing on the same channel in the same cycle. The other is a second error report arriving while the status word is frozen, or in the exact cycle software releases it. Directed steps line these collisions up on purpose. A long seeded random phase then mixes byte-strobed writes, command bytes with channel values up to 79 (so out-of-range commands occur), sparse done events and error reports. This lets collisions and strobe combinations arise that the directed steps do not list. Every cycle, a bench model built from the requirements predicts the interrupt line, the strobes and one read-back register.

// File: rtl/dmac_rb_pkg.sv
package dmac_rb_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_ESTAT  = 8'h04;
  localparam logic [7:0] OFS_REQ_HI = 8'h08;
  localparam logic [7:0] OFS_REQ_LO = 8'h0C;
  localparam logic [7:0] OFS_EEI_HI = 8'h10;
  localparam logic [7:0] OFS_EEI_LO = 8'h14;
  localparam logic [7:0] OFS_CMD_A  = 8'h18;
  localparam logic [7:0] OFS_CMD_B  = 8'h1C;
  localparam logic [7:0] OFS_INT_HI = 8'h20;
  localparam logic [7:0] OFS_INT_LO = 8'h24;
  localparam logic [7:0] OFS_ERR_HI = 8'h28;
  localparam logic [7:0] OFS_ERR_LO = 8'h2C;

  // lanes of command word A
  localparam int LANE_REQ_SET = 0;
  localparam int LANE_REQ_CLR = 1;
  localparam int LANE_EEI_SET = 2;
  localparam int LANE_EEI_CLR = 3;
  // lanes of command word B
  localparam int LANE_INT_CLR  = 0;
  localparam int LANE_ERR_CLR  = 1;
  localparam int LANE_START    = 2;
  localparam int LANE_DONE_CLR = 3;

  localparam int CAUSE_W = 10;
  localparam int CHAN_W  = 6;
endpackage

// File: rtl/dmac_rb_bitmap.sv
module dmac_rb_bitmap #(
  parameter int N   = 64,
  parameter bit W1C = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] wmask_i,
  input  logic [N-1:0] wval_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_nxt;
  logic [N-1:0] kept;
  logic         upd;

  generate
    if (W1C) begin : g_w1c
      assign kept = q_o & ~(wmask_i & wval_i);
    end else begin : g_rw
      assign kept = (q_o & ~wmask_i) | (wval_i & wmask_i);
    end
  endgenerate

  always_comb begin
    q_nxt = (kept & ~clr_i) | set_i;
    upd   = (|set_i) | (|clr_i) | (|wmask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_o <= '0;
    else if (upd) q_o <= q_nxt;
  end
endmodule

// File: rtl/dmac_rb_cmd_decode.sv
module dmac_rb_cmd_decode #(
  parameter int N = 64
) (
  input  logic                hit_i,
  input  logic [3:0]          strb_i,
  input  logic [31:0]         wdata_i,
  output logic [3:0][N-1:0]   mask_o
);
  generate
    for (genvar k = 0; k < 4; k++) begin : g_lane
      for (genvar c = 0; c < N; c++) begin : g_ch
        assign mask_o[k][c] = hit_i && strb_i[k] && (wdata_i[8*k +: 8] == 8'(c));
      end
    end
  endgenerate
endmodule

// File: rtl/dmac_rb_errstat.sv
module dmac_rb_errstat (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rpt_valid_i,
  input  logic [5:0]  rpt_chan_i,
  input  logic [9:0]  rpt_cause_i,
  input  logic        clr_i,
  output logic [31:0] status_o
);
  logic [31:0] st_nxt;
  logic        capture;
  logic        upd;

  always_comb begin
    capture = rpt_valid_i && (!status_o[31] || clr_i);
    upd     = capture || clr_i;
    if (capture)
      st_nxt = {1'b1, 15'b0, rpt_cause_i[9], rpt_cause_i[8], rpt_chan_i, rpt_cause_i[7:0]};
    else
      st_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_o <= '0;
    else if (upd) status_o <= st_nxt;
  end
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
  import dmac_rb_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [3:0]        reg_wstrb,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] ch_done_evt,
  input  logic              err_rpt_valid,
  input  logic [5:0]        err_rpt_chan,
  input  logic [9:0]        err_rpt_cause,
  output logic [NUM_CH-1:0] ch_req_en,
  output logic [NUM_CH-1:0] ch_start,
  output logic [NUM_CH-1:0] ch_done_clr,
  output logic              ctrl_dyn_clk,
  output logic              ctrl_rr_group,
  output logic              ctrl_rr_chan,
  output logic              irq
);
  localparam int FULL_W = 64;

  // byte-lane mask and word hits
  logic [31:0] bmask;
  logic hit_ctrl, hit_estat, hit_cmd_a, hit_cmd_b;
  logic hit_req_hi, hit_req_lo, hit_eei_hi, hit_eei_lo;
  logic hit_int_hi, hit_int_lo, hit_err_hi, hit_err_lo;

  assign bmask = {{8{reg_wstrb[3]}}, {8{reg_wstrb[2]}}, {8{reg_wstrb[1]}}, {8{reg_wstrb[0]}}};

  always_comb begin
    hit_ctrl   = reg_wr_en && (reg_addr == OFS_CTRL);
    hit_estat  = reg_wr_en && (reg_addr == OFS_ESTAT);
    hit_req_hi = reg_wr_en && (reg_addr == OFS_REQ_HI);
    hit_req_lo = reg_wr_en && (reg_addr == OFS_REQ_LO);
    hit_eei_hi = reg_wr_en && (reg_addr == OFS_EEI_HI);
    hit_eei_lo = reg_wr_en && (reg_addr == OFS_EEI_LO);
    hit_cmd_a  = reg_wr_en && (reg_addr == OFS_CMD_A);
    hit_cmd_b  = reg_wr_en && (reg_addr == OFS_CMD_B);
    hit_int_hi = reg_wr_en && (reg_addr == OFS_INT_HI);
    hit_int_lo = reg_wr_en && (reg_addr == OFS_INT_LO);
    hit_err_hi = reg_wr_en && (reg_addr == OFS_ERR_HI);
    hit_err_lo = reg_wr_en && (reg_addr == OFS_ERR_LO);
  end

  // 64-bit write views, truncated to the channel count
  logic [FULL_W-1:0] wval64;
  logic [FULL_W-1:0] req_wm64, eei_wm64, int_wm64, err_wm64;

  always_comb begin
    wval64   = {reg_wdata, reg_wdata};
    req_wm64 = {hit_req_hi ? bmask : 32'b0, hit_req_lo ? bmask : 32'b0};
    eei_wm64 = {hit_eei_hi ? bmask : 32'b0, hit_eei_lo ? bmask : 32'b0};
    int_wm64 = {hit_int_hi ? bmask : 32'b0, hit_int_lo ? bmask : 32'b0};
    err_wm64 = {hit_err_hi ? bmask : 32'b0, hit_err_lo ? bmask : 32'b0};
  end

  // command decoding
  logic [3:0][NUM_CH-1:0] cmd_a, cmd_b;

  dmac_rb_cmd_decode #(.N(NUM_CH)) u_cmd_a (
    .hit_i(hit_cmd_a), .strb_i(reg_wstrb), .wdata_i(reg_wdata), .mask_o(cmd_a));
  dmac_rb_cmd_decode #(.N(NUM_CH)) u_cmd_b (
    .hit_i(hit_cmd_b), .strb_i(reg_wstrb), .wdata_i(reg_wdata), .mask_o(cmd_b));

  // error report as a one-hot set vector
  logic [NUM_CH-1:0] err_set;
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_eset
      assign err_set[c] = err_rpt_valid && (err_rpt_chan == 6'(c));
    end
  endgenerate

  // bitmaps
  logic [NUM_CH-1:0] req_q, eei_q, int_q, err_q;
  logic [NUM_CH-1:0] zero_n;
  assign zero_n = '0;

  dmac_rb_bitmap #(.N(NUM_CH), .W1C(1'b0)) u_req (
    .clk(clk), .rst_n(rst_n),
    .set_i(cmd_a[LANE_REQ_SET]), .clr_i(cmd_a[LANE_REQ_CLR]),
    .wmask_i(req_wm64[NUM_CH-1:0]), .wval_i(wval64[NUM_CH-1:0]), .q_o(req_q));

  dmac_rb_bitmap #(.N(NUM_CH), .W1C(1'b0)) u_eei (
    .clk(clk), .rst_n(rst_n),
    .set_i(cmd_a[LANE_EEI_SET]), .clr_i(cmd_a[LANE_EEI_CLR]),
    .wmask_i(eei_wm64[NUM_CH-1:0]), .wval_i(wval64[NUM_CH-1:0]), .q_o(eei_q));

  dmac_rb_bitmap #(.N(NUM_CH), .W1C(1'b1)) u_int (
    .clk(clk), .rst_n(rst_n),
    .set_i(ch_done_evt), .clr_i(cmd_b[LANE_INT_CLR]),
    .wmask_i(int_wm64[NUM_CH-1:0]), .wval_i(wval64[NUM_CH-1:0]), .q_o(int_q));

  dmac_rb_bitmap #(.N(NUM_CH), .W1C(1'b1)) u_err (
    .clk(clk), .rst_n(rst_n),
    .set_i(err_set), .clr_i(cmd_b[LANE_ERR_CLR]),
    .wmask_i(err_wm64[NUM_CH-1:0]), .wval_i(wval64[NUM_CH-1:0]), .q_o(err_q));

  // error status capture
  logic [31:0] estat_q;
  logic        estat_clr;
  assign estat_clr = hit_estat && reg_wstrb[3] && reg_wdata[31];

  dmac_rb_errstat u_estat (
    .clk(clk), .rst_n(rst_n),
    .rpt_valid_i(err_rpt_valid), .rpt_chan_i(err_rpt_chan), .rpt_cause_i(err_rpt_cause),
    .clr_i(estat_clr), .status_o(estat_q));

  // control word
  logic [2:0] ctrl_q, ctrl_nxt;
  logic       ctrl_upd;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (reg_wstrb[3]) ctrl_nxt[2]   = reg_wdata[31];
    if (reg_wstrb[0]) ctrl_nxt[1:0] = reg_wdata[3:2];
    ctrl_upd = hit_ctrl && (reg_wstrb[3] || reg_wstrb[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (ctrl_upd) ctrl_q <= ctrl_nxt;
  end

  // strobe registers
  logic [NUM_CH-1:0] start_q, dclr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      dclr_q  <= '0;
    end else begin
      start_q <= cmd_b[LANE_START];
      dclr_q  <= cmd_b[LANE_DONE_CLR];
    end
  end

  // read mux
  logic [FULL_W-1:0] req64, eei64, int64, err64;
  always_comb begin
    req64 = 64'(req_q);
    eei64 = 64'(eei_q);
    int64 = 64'(int_q);
    err64 = 64'(err_q);
    case (reg_addr)
      OFS_CTRL:   reg_rdata = {ctrl_q[2], 27'b0, ctrl_q[1:0], 2'b0};
      OFS_ESTAT:  reg_rdata = estat_q;
      OFS_REQ_HI: reg_rdata = req64[63:32];
      OFS_REQ_LO: reg_rdata = req64[31:0];
      OFS_EEI_HI: reg_rdata = eei64[63:32];
      OFS_EEI_LO: reg_rdata = eei64[31:0];
      OFS_INT_HI: reg_rdata = int64[63:32];
      OFS_INT_LO: reg_rdata = int64[31:0];
      OFS_ERR_HI: reg_rdata = err64[63:32];
      OFS_ERR_LO: reg_rdata = err64[31:0];
      default:    reg_rdata = 32'b0;
    endcase
  end

  assign ch_req_en     = req_q;
  assign ch_start      = start_q;
  assign ch_done_clr   = dclr_q;
  assign ctrl_dyn_clk  = ctrl_q[2];
  assign ctrl_rr_group = ctrl_q[1];
  assign ctrl_rr_chan  = ctrl_q[0];
  assign irq           = (|int_q) || (|(err_q & eei_q));
endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk #(
  parameter int NUM_CH = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [NUM_CH-1:0] ch_done_evt,
  input logic [NUM_CH-1:0] int_pend,
  input logic [NUM_CH-1:0] err_pend,
  input logic [NUM_CH-1:0] ch_start,
  input logic [NUM_CH-1:0] ch_done_clr,
  input logic              err_rpt_valid,
  input logic [31:0]       estat
);
  a_r5_done_sets_int: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (|$past(ch_done_evt))) |->
      ((int_pend & $past(ch_done_evt)) == $past(ch_done_evt)));

  a_r6_report_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(err_rpt_valid)) |-> (err_pend != '0));

  a_r7_report_leaves_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(err_rpt_valid)) |-> estat[31]);

  a_r7_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(estat[31]) && estat[31] && !$past(err_rpt_valid)) |->
      (estat == $past(estat)));

  a_r8_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (|$past(ch_done_evt))) |-> irq);

  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start));

  a_r9_done_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_done_clr));
endmodule

bind dmac_regbank dmac_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ch_done_evt(ch_done_evt),
  .int_pend(int_q), .err_pend(err_q), .ch_start(ch_start), .ch_done_clr(ch_done_clr),
  .err_rpt_valid(err_rpt_valid), .estat(estat_q));

// File: tb/dmac_regbank_tb_top.sv
`timescale 1ns/1ps
module dmac_regbank_tb_top;
  localparam int NCH = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic           wr_en;
  logic [7:0]     addr;
  logic [3:0]     strb;
  logic [31:0]    wdata;
  logic [31:0]    rdata;
  logic [NCH-1:0] done_evt;
  logic           rv;
  logic [5:0]     rchan;
  logic [9:0]     rcause;
  logic [NCH-1:0] req_en, start, dclr;
  logic           c_dyn, c_rrg, c_rrc, irq;

  dmac_regbank #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr), .reg_wstrb(strb),
    .reg_wdata(wdata), .reg_rdata(rdata), .ch_done_evt(done_evt),
    .err_rpt_valid(rv), .err_rpt_chan(rchan), .err_rpt_cause(rcause),
    .ch_req_en(req_en), .ch_start(start), .ch_done_clr(dclr),
    .ctrl_dyn_clk(c_dyn), .ctrl_rr_group(c_rrg), .ctrl_rr_chan(c_rrc), .irq(irq));

  int n_chk = 0;
  int n_fail = 0;

  // model state
  logic [63:0] m_req, m_eei, m_int, m_err, m_start, m_dclr;
  logic [31:0] m_est;
  logic [2:0]  m_ctrl;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [63:0] cmd_sel(logic [7:0] ofs, int lane);
    logic [7:0] b;
    b = wdata[8*lane +: 8];
    if (wr_en && addr == ofs && strb[lane] && b < 8'd64) return 64'd1 << b;
    return 64'd0;
  endfunction

  task automatic model_step();
    logic [31:0] bm;
    logic [31:0] old;
    logic        clr;
    bm  = {{8{strb[3]}}, {8{strb[2]}}, {8{strb[1]}}, {8{strb[0]}}};
    old = m_est;
    if (wr_en && addr == 8'h08) m_req[63:32] = (m_req[63:32] & ~bm) | (wdata & bm);
    if (wr_en && addr == 8'h0C) m_req[31:0]  = (m_req[31:0]  & ~bm) | (wdata & bm);
    m_req = (m_req & ~cmd_sel(8'h18, 1)) | cmd_sel(8'h18, 0);
    if (wr_en && addr == 8'h10) m_eei[63:32] = (m_eei[63:32] & ~bm) | (wdata & bm);
    if (wr_en && addr == 8'h14) m_eei[31:0]  = (m_eei[31:0]  & ~bm) | (wdata & bm);
    m_eei = (m_eei & ~cmd_sel(8'h18, 3)) | cmd_sel(8'h18, 2);
    if (wr_en && addr == 8'h20) m_int[63:32] = m_int[63:32] & ~(wdata & bm);
    if (wr_en && addr == 8'h24) m_int[31:0]  = m_int[31:0]  & ~(wdata & bm);
    m_int = (m_int & ~cmd_sel(8'h1C, 0)) | done_evt;
    if (wr_en && addr == 8'h28) m_err[63:32] = m_err[63:32] & ~(wdata & bm);
    if (wr_en && addr == 8'h2C) m_err[31:0]  = m_err[31:0]  & ~(wdata & bm);
    m_err = (m_err & ~cmd_sel(8'h1C, 1)) | (rv ? (64'd1 << rchan) : 64'd0);
    m_start = cmd_sel(8'h1C, 2);
    m_dclr  = cmd_sel(8'h1C, 3);
    clr = wr_en && addr == 8'h04 && strb[3] && wdata[31];
    if (rv && (!old[31] || clr))
      m_est = {1'b1, 15'b0, rcause[9], rcause[8], rchan, rcause[7:0]};
    else if (clr)
      m_est = 32'd0;
    if (wr_en && addr == 8'h00) begin
      if (strb[3]) m_ctrl[2] = wdata[31];
      if (strb[0]) m_ctrl[1:0] = wdata[3:2];
    end
  endtask

  function automatic logic [31:0] exp_reg(logic [7:0] a);
    case (a)
      8'h00: return {m_ctrl[2], 27'b0, m_ctrl[1:0], 2'b0};
      8'h04: return m_est;
      8'h08: return m_req[63:32];
      8'h0C: return m_req[31:0];
      8'h10: return m_eei[63:32];
      8'h14: return m_eei[31:0];
      8'h20: return m_int[63:32];
      8'h24: return m_int[31:0];
      8'h28: return m_err[63:32];
      8'h2C: return m_err[31:0];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R2 ctrl";
      8'h04: return "R7 estat";
      8'h08, 8'h0C: return "R3 req";
      8'h10, 8'h14: return "R4 eei";
      8'h20, 8'h24: return "R5 int";
      8'h28, 8'h2C: return "R6 err";
      default: return "R11 unmapped";
    endcase
  endfunction

  task automatic idle();
    wr_en = 0; addr = 8'h00; strb = 4'h0; wdata = 32'h0;
    done_evt = '0; rv = 0; rchan = 6'h0; rcause = 10'h0;
  endtask

  // one clock: inputs already driven at a falling edge
  task automatic do_cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
    #1;
    chk("R8 irq", {63'b0, irq}, {63'b0, (|m_int) || (|(m_err & m_eei))});
    chk("R9 start strobe", start, m_start);
    chk("R9 done-clear strobe", dclr, m_dclr);
    chk("R3 req_en out", req_en, m_req);
    chk("R2 ctrl out", {61'b0, c_dyn, c_rrg, c_rrc}, {61'b0, m_ctrl});
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] s, logic [31:0] d);
    wr_en = 1; addr = a; strb = s; wdata = d;
    do_cycle();
  endtask

  task automatic rd_chk(logic [7:0] a);
    wr_en = 0; addr = a;
    #1;
    chk(tag_of(a), {32'b0, rdata}, {32'b0, exp_reg(a)});
  endtask

  task automatic rd_exp(string tag, logic [7:0] a, logic [31:0] e);
    wr_en = 0; addr = a;
    #1;
    chk(tag, {32'b0, rdata}, {32'b0, e});
  endtask

  localparam int NREG = 13;
  function automatic logic [7:0] reg_at(int i);
    logic [7:0] t [NREG] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                             8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30};
    return t[i];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    m_req = 0; m_eei = 0; m_int = 0; m_err = 0; m_start = 0; m_dclr = 0;
    m_est = 0; m_ctrl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    for (int i = 0; i < NREG; i++) rd_exp("R1 reset value", reg_at(i), 32'd0);
    chk("R1 irq low", {63'b0, irq}, 64'd0);
    chk("R1 outputs low", req_en | start | dclr, 64'd0);

    // R11 / R3: channel 40 lands in the high word, bit 8
    wr(8'h18, 4'b0001, 32'd40);
    rd_exp("R11 high word bit", 8'h08, 32'h0000_0100);
    rd_exp("R11 low word untouched", 8'h0C, 32'h0);
    chk("R3 req_en channel 40", req_en, 64'd1 << 40);

    // R10: out-of-range command bytes
    wr(8'h18, 4'b0101, 32'h00C8_0040);
    rd_exp("R10 req high unchanged", 8'h08, 32'h0000_0100);
    rd_exp("R10 eei unchanged", 8'h10, 32'h0);
    wr(8'h1C, 4'b0100, 32'h0046_0000);
    chk("R10 no start strobe", start, 64'd0);

    // R9: start channel 3, strobe lasts one cycle
    wr_en = 1; addr = 8'h1C; strb = 4'b0100; wdata = 32'h0003_0000;
    @(posedge clk); model_step(); @(negedge clk); idle(); #1;
    chk("R9 start channel 3", start, 64'd8);
    do_cycle();
    chk("R9 start strobe dropped", start, 64'd0);

    // R2 control word
    wr(8'h00, 4'b1001, 32'hFFFF_FFFF);
    rd_exp("R2 ctrl readback", 8'h00, 32'h8000_000C);

    // R5: done event beats same-cycle command clear
    done_evt = 64'd1 << 5;
    wr(8'h1C, 4'b0001, 32'd5);
    rd_exp("R5 set wins over clear", 8'h24, 32'h20);
    chk("R8 irq from done", {63'b0, irq}, 64'd1);
    wr(8'h24, 4'b1111, 32'hFFFF_FFFF);
    rd_exp("R5 all-ones clears word", 8'h24, 32'h0);
    chk("R8 irq low after clear", {63'b0, irq}, 64'd0);

    // R7/R6/R8: error capture and masking
    rv = 1; rchan = 6'd9; rcause = 10'h2A1;
    do_cycle();
    rd_exp("R7 captured word", 8'h04, 32'h8000_89A1);
    rd_exp("R6 error bit 9", 8'h2C, 32'h200);
    chk("R8 error masked", {63'b0, irq}, 64'd0);
    wr(8'h18, 4'b0100, 32'h0009_0000);
    chk("R8 enabled error raises irq", {63'b0, irq}, 64'd1);
    rv = 1; rchan = 6'd12; rcause = 10'h001;
    do_cycle();
    rd_exp("R7 second error ignored", 8'h04, 32'h8000_89A1);
    wr(8'h04, 4'b1000, 32'h8000_0000);
    rd_exp("R7 cleared", 8'h04, 32'h0);
    wr(8'h1C, 4'b0010, 32'h0000_0900);
    chk("R6 clear error 9 drops irq", {63'b0, irq}, 64'd0);

    // random phase
    for (int it = 0; it < 1500; it++) begin
      if ($urandom_range(0, 1) == 1) begin
        wr_en = 1;
        addr  = reg_at($urandom_range(0, NREG - 1));
        strb  = 4'($urandom);
        if (addr == 8'h18 || addr == 8'h1C)
          wdata = {8'($urandom_range(0, 79)), 8'($urandom_range(0, 79)),
                   8'($urandom_range(0, 79)), 8'($urandom_range(0, 79))};
        else
          wdata = $urandom;
      end
      if ($urandom_range(0, 3) == 0) done_evt = 64'd1 << $urandom_range(0, 63);
      if ($urandom_range(0, 7) == 0) begin
        rv = 1; rchan = 6'($urandom); rcause = 10'($urandom);
      end
      do_cycle();
      rd_chk(reg_at($urandom_range(0, NREG - 1)));
    end

    summary();
    $finish;
  end
endmodule